// File: doc/BRIEF.md
# Windowed Watchdog Timer with Interrupt-Then-Reset Escalation

The block is a watchdog built on a down counter. Software programs a time-out value and a window threshold and enables the count. After that it must prove it is alive by writing a two-word key pair to a service register, which reloads the counter. The counter steps down once per cycle in which the `tick` input is high. If the counter runs out, the block either requests a system reset at once or first raises an interrupt and reloads, then requests reset on a second time-out in a row.

Window mode restricts servicing to the tail of the period: a key write counts only while the counter is below the window threshold. Any key write outside the window, with a wrong value, or out of order is an invalid access. Depending on a control bit, an invalid access produces a one-cycle bus error pulse or a reset request. While the watchdog is disabled the count is frozen and can be read back, which supports a software self-test of the counter.

Register map (3-bit word address, write data and read data on separate ports): 0 control, 1 time-out, 2 window, 3 service key, 4 status, 5 count observation. Control bits: bit 0 enable, bit 1 window mode, bit 2 interrupt-then-reset, bit 3 invalid-access-resets. Status bit 0 is the time-out flag.

Top module: `win_watchdog`

## Requirements
- R1: After reset the watchdog is disabled, control reads 0, time-out reads its reset value (all ones), the observation register reads 0, and `irq`, `rst_req` and `bus_err` are low.
- R2: Writing control with bit 0 set while disabled loads the counter from the time-out register. Each `tick` cycle while enabled decrements it. The observation register (address 5) reads 0 while enabled. It reads the frozen count while disabled, and `tick` does not change it then.
- R3: With bit 2 clear, the tick that takes the counter from 1 to 0 produces a one-cycle `rst_req` pulse and reloads the counter from the time-out register.
- R4: With bit 2 set, the first time-out sets status bit 0 and reloads the counter without reset. A second time-out with no valid service in between pulses `rst_req`.
- R5: A valid service is 16'hA602 followed by 16'hB480, written to address 3 (low 16 bits). It reloads the counter from the time-out register and cancels a pending first time-out.
- R6: With window mode (bit 1) set, a key write is valid only while the counter is strictly below the window register. With time-out 5000 and window 1000, a service after 4000 ticks (count 1000) is invalid and one after 4001 ticks is accepted.
- R7: With window mode clear, a correct key pair is accepted at any count.
- R8: A key write with another value, or 16'hB480 without a preceding 16'hA602, is an invalid access and does not reload the counter.
- R9: An invalid access produces a one-cycle `bus_err` pulse when control bit 3 is clear, and a one-cycle `rst_req` pulse instead when bit 3 is set.
- R10: Writing status with bit 0 set clears the time-out flag. Writing it with bit 0 clear leaves the flag unchanged.
- R11: `irq` is high exactly when the time-out flag is set and control bit 2 is set.
- R12: Key writes while the watchdog is disabled are ignored: no `bus_err`, no `rst_req`, no change to the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick | input | 1 | Counter enable: one decrement per high cycle |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data for `reg_addr` (combinational) |
| bus_err | output | 1 | One-cycle error response to an invalid access |
| irq | output | 1 | Time-out interrupt request |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
The hardest situation to reach is a service write at an exact count at the window edge, because the count cannot be read while the watchdog runs. The bench drives `tick` for an exact number of cycles, so it knows the count without reading it. It then writes the keys and disables the watchdog. The frozen count in the observation register then shows whether the service reloaded the counter. Bus error pulses are counted alongside. Escalation is reached the same way: exact tick runs to the first time-out, with and without a service before the second.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned ADR_W = 3;

  localparam logic [ADR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADR_W-1:0] A_TMO  = 3'd1;
  localparam logic [ADR_W-1:0] A_WIN  = 3'd2;
  localparam logic [ADR_W-1:0] A_SVC  = 3'd3;
  localparam logic [ADR_W-1:0] A_STAT = 3'd4;
  localparam logic [ADR_W-1:0] A_OBS  = 3'd5;

  localparam int unsigned KEY_W = 16;
  localparam logic [KEY_W-1:0] KEY_FIRST  = 16'hA602;
  localparam logic [KEY_W-1:0] KEY_SECOND = 16'hB480;

  typedef enum logic {SVC_IDLE, SVC_HALF} svc_st_e;

  // bit 0 = en ... bit 3 = irs
  typedef struct packed {
    logic irs;
    logic itr;
    logic wm;
    logic en;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/wdt_rst_sync.sv
module wdt_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign rst_n_o = sh_q[STAGES-1];
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int unsigned      CNT_W   = 16,
  parameter int unsigned      DW      = 32,
  parameter logic [CNT_W-1:0] TMO_RST = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [ADR_W-1:0] addr,
  input  logic [DW-1:0]    wdata,
  input  logic             tif_set,
  output ctrl_t            ctrl,
  output logic [CNT_W-1:0] tmo,
  output logic [CNT_W-1:0] win,
  output logic             tif,
  output logic             arm,
  output logic             svc_wr,
  output logic [KEY_W-1:0] svc_key
);
  ctrl_t            ctrl_d;
  logic [CNT_W-1:0] tmo_d;
  logic [CNT_W-1:0] win_d;
  logic             tif_d;

  always_comb begin
    ctrl_d = ctrl;
    tmo_d  = tmo;
    win_d  = win;
    tif_d  = tif;
    if (wr) begin
      case (addr)
        A_CTRL:  ctrl_d = ctrl_t'(wdata[CTRL_W-1:0]);
        A_TMO:   tmo_d  = wdata[CNT_W-1:0];
        A_WIN:   win_d  = wdata[CNT_W-1:0];
        A_STAT:  if (wdata[0]) tif_d = 1'b0;
        default: ;
      endcase
    end
    if (tif_set) tif_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
      tmo  <= TMO_RST;
      win  <= '0;
      tif  <= 1'b0;
    end else begin
      ctrl <= ctrl_d;
      tmo  <= tmo_d;
      win  <= win_d;
      tif  <= tif_d;
    end
  end

  assign arm     = wr && (addr == A_CTRL) && wdata[0] && !ctrl.en;
  assign svc_wr  = wr && (addr == A_SVC);
  assign svc_key = wdata[KEY_W-1:0];
endmodule

// File: rtl/wdt_service.sv
module wdt_service
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctrl_t            ctrl,
  input  logic             svc_wr,
  input  logic [KEY_W-1:0] svc_key,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] win,
  output logic             svc_ok,
  output logic             bad_err,
  output logic             bad_rst
);
  svc_st_e st_q;
  svc_st_e st_d;
  logic    win_open;
  logic    bad;

  assign win_open = !ctrl.wm || (cnt < win);

  always_comb begin
    st_d   = st_q;
    svc_ok = 1'b0;
    bad    = 1'b0;
    if (!ctrl.en) begin
      st_d = SVC_IDLE;
    end else if (svc_wr) begin
      if (!win_open) begin
        bad  = 1'b1;
        st_d = SVC_IDLE;
      end else if (st_q == SVC_IDLE) begin
        if (svc_key == KEY_FIRST) st_d = SVC_HALF;
        else                      bad  = 1'b1;
      end else begin
        st_d = SVC_IDLE;
        if (svc_key == KEY_SECOND) svc_ok = 1'b1;
        else                       bad    = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SVC_IDLE;
    else        st_q <= st_d;
  end

  assign bad_err = bad && !ctrl.irs;
  assign bad_rst = bad &&  ctrl.irs;
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctrl_t            ctrl,
  input  logic             arm,
  input  logic             tick,
  input  logic             svc_ok,
  input  logic [CNT_W-1:0] tmo,
  output logic [CNT_W-1:0] cnt,
  output logic             tif_set,
  output logic             to_rst
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_d;
  logic             stage_q;
  logic             stage_d;
  logic             expire;

  assign expire = tick && (cnt <= ONE);

  always_comb begin
    cnt_d   = cnt;
    stage_d = stage_q;
    tif_set = 1'b0;
    to_rst  = 1'b0;
    if (arm) begin
      cnt_d   = tmo;
      stage_d = 1'b0;
    end else if (ctrl.en) begin
      if (svc_ok) begin
        cnt_d   = tmo;
        stage_d = 1'b0;
      end else if (expire) begin
        cnt_d = tmo;
        if (ctrl.itr && !stage_q) begin
          tif_set = 1'b1;
          stage_d = 1'b1;
        end else begin
          to_rst  = 1'b1;
          stage_d = 1'b0;
        end
      end else if (tick) begin
        cnt_d = cnt - ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      stage_q <= 1'b0;
    end else begin
      cnt     <= cnt_d;
      stage_q <= stage_d;
    end
  end
endmodule

// File: rtl/win_watchdog.sv
module win_watchdog
  import wdt_pkg::*;
#(
  parameter int unsigned      CNT_W       = 16,
  parameter int unsigned      DW          = 32,
  parameter logic [CNT_W-1:0] TMO_RST     = '1,
  parameter int unsigned      SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             reg_wr,
  input  logic [ADR_W-1:0] reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  output logic             bus_err,
  output logic             irq,
  output logic             rst_req
);
  logic             rst_s_n;
  ctrl_t            ctrl;
  logic [CNT_W-1:0] tmo;
  logic [CNT_W-1:0] win;
  logic [CNT_W-1:0] cnt;
  logic             tif;
  logic             tif_set;
  logic             arm;
  logic             svc_wr;
  logic [KEY_W-1:0] svc_key;
  logic             svc_ok;
  logic             bad_err;
  logic             bad_rst;
  logic             to_rst;
  logic             rst_req_d;
  logic             bus_err_d;

  wdt_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .arst_n(rst_n), .rst_n_o(rst_s_n)
  );

  wdt_regs #(.CNT_W(CNT_W), .DW(DW), .TMO_RST(TMO_RST)) u_regs (
    .clk(clk), .rst_n(rst_s_n), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .tif_set(tif_set), .ctrl(ctrl), .tmo(tmo),
    .win(win), .tif(tif), .arm(arm), .svc_wr(svc_wr), .svc_key(svc_key)
  );

  wdt_service #(.CNT_W(CNT_W)) u_svc (
    .clk(clk), .rst_n(rst_s_n), .ctrl(ctrl), .svc_wr(svc_wr),
    .svc_key(svc_key), .cnt(cnt), .win(win), .svc_ok(svc_ok),
    .bad_err(bad_err), .bad_rst(bad_rst)
  );

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_s_n), .ctrl(ctrl), .arm(arm), .tick(tick),
    .svc_ok(svc_ok), .tmo(tmo), .cnt(cnt), .tif_set(tif_set),
    .to_rst(to_rst)
  );

  always_comb begin
    rst_req_d = to_rst || bad_rst;
    bus_err_d = bad_err;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      rst_req <= 1'b0;
      bus_err <= 1'b0;
    end else begin
      rst_req <= rst_req_d;
      bus_err <= bus_err_d;
    end
  end

  assign irq = tif && ctrl.itr;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL:  reg_rdata[CTRL_W-1:0] = ctrl;
      A_TMO:   reg_rdata[CNT_W-1:0]  = tmo;
      A_WIN:   reg_rdata[CNT_W-1:0]  = win;
      A_STAT:  reg_rdata[0]          = tif;
      A_OBS:   if (!ctrl.en) reg_rdata[CNT_W-1:0] = cnt;
      default: ;
    endcase
  end
endmodule

// File: rtl/wdt_chk.sv
module wdt_chk
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input ctrl_t            ctrl,
  input logic [CNT_W-1:0] tmo,
  input logic [CNT_W-1:0] cnt,
  input logic             svc_ok,
  input logic             tif,
  input logic             bus_err
);
  // R2: enabling loads the time-out value
  p_load_on_enable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl.en) |-> cnt == tmo);

  // R2: count frozen while disabled
  p_frozen_when_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.en && !$past(ctrl.en)) |-> cnt == $past(cnt));

  // R5: accepted service reloads the counter
  p_reload_on_service_r5: assert property (@(posedge clk) disable iff (!rst_n)
    svc_ok |=> cnt == $past(tmo));

  // R4: the flag rises only in interrupt-then-reset mode
  p_flag_needs_itr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tif) |-> $past(ctrl.itr));

  // R9: bus error only when invalid access is set to error response
  p_err_select_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> !ctrl.irs);
endmodule

bind win_watchdog wdt_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_s_n), .ctrl(ctrl), .tmo(tmo), .cnt(cnt),
  .svc_ok(svc_ok), .tif(tif), .bus_err(bus_err)
);

// File: tb/sim_win_watchdog.sv
module sim_win_watchdog;
  localparam int CLK_P = 10;
  localparam int DW    = 32;

  logic          clk;
  logic          rst_n;
  logic          tick;
  logic          reg_wr;
  logic [2:0]    reg_addr;
  logic [DW-1:0] reg_wdata;
  logic [DW-1:0] reg_rdata;
  logic          bus_err;
  logic          irq;
  logic          rst_req;

  int n_chk  = 0;
  int n_fail = 0;
  int n_rst  = 0;
  int n_err  = 0;

  // fields: tmo[49:34] win[33:18] ticks[17:2] wmode[1] accept[0]
  localparam logic [49:0] VEC [0:7] = '{
    {16'd100,  16'd20,   16'd80,   1'b1, 1'b0},
    {16'd100,  16'd20,   16'd81,   1'b1, 1'b1},
    {16'd5000, 16'd1000, 16'd4000, 1'b1, 1'b0},
    {16'd5000, 16'd1000, 16'd4001, 1'b1, 1'b1},
    {16'd50,   16'd50,   16'd0,    1'b1, 1'b0},
    {16'd50,   16'd0,    16'd49,   1'b1, 1'b0},
    {16'd64,   16'd10,   16'd3,    1'b0, 1'b1},
    {16'd64,   16'd10,   16'd63,   1'b0, 1'b1}
  };

  win_watchdog u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .bus_err(bus_err), .irq(irq), .rst_req(rst_req)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  always @(posedge clk) begin
    #1;
    if (rst_req) n_rst++;
    if (bus_err) n_err++;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic ticks(input int n);
    if (n > 0) begin
      @(negedge clk);
      tick = 1'b1;
      repeat (n) @(negedge clk);
      tick = 1'b0;
    end
  endtask

  task automatic service();
    wr_reg(3'd3, 32'h0000_A602);
    wr_reg(3'd3, 32'h0000_B480);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_P * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    int r0, e0;
    rst_n = 1'b0; tick = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd_reg(3'd0, rd); check("R1 ctrl", rd, 0);
    rd_reg(3'd1, rd); check("R1 tmo", rd, 32'hFFFF);
    rd_reg(3'd5, rd); check("R1 obs", rd, 0);
    check("R1 irq", irq, 0);
    check("R1 pulses", n_rst + n_err, 0);

    // R5 R6 R7 window table
    for (int i = 0; i < 8; i++) begin
      logic [15:0] t, w, n;
      logic        wm, ok;
      {t, w, n, wm, ok} = VEC[i];
      wr_reg(3'd1, {16'd0, t});
      wr_reg(3'd2, {16'd0, w});
      wr_reg(3'd0, {30'd0, wm, 1'b1});
      ticks(int'(n));
      e0 = n_err;
      service();
      @(negedge clk);
      check(wm ? "R6 window errors" : "R7 no-window errors", n_err - e0, ok ? 0 : 2);
      wr_reg(3'd0, 32'd0);
      rd_reg(3'd5, rd);
      check(ok ? "R5 reload count" : "R8 no reload count", rd, ok ? t : t - n);
    end

    // R2 self-test
    wr_reg(3'd1, 32'd300);
    wr_reg(3'd0, 32'd1);
    ticks(37);
    rd_reg(3'd5, rd); check("R2 obs zero while enabled", rd, 0);
    wr_reg(3'd0, 32'd0);
    rd_reg(3'd5, rd); check("R2 frozen count", rd, 263);
    ticks(5);
    rd_reg(3'd5, rd); check("R2 no tick while off", rd, 263);

    // R3 immediate reset
    wr_reg(3'd1, 32'd10);
    wr_reg(3'd0, 32'd1);
    r0 = n_rst;
    ticks(9); @(negedge clk);
    check("R3 no reset before zero", n_rst - r0, 0);
    ticks(1); @(negedge clk);
    check("R3 reset at zero", n_rst - r0, 1);
    wr_reg(3'd0, 32'd0);
    rd_reg(3'd5, rd); check("R3 reload", rd, 10);

    // R4 R10 R11 escalation
    wr_reg(3'd0, 32'h5);
    r0 = n_rst;
    ticks(10); @(negedge clk);
    rd_reg(3'd4, rd); check("R4 flag set", rd, 1);
    check("R11 irq high", irq, 1);
    check("R4 no reset first", n_rst - r0, 0);
    wr_reg(3'd4, 32'd0);
    rd_reg(3'd4, rd); check("R10 write 0 keeps flag", rd, 1);
    wr_reg(3'd0, 32'h1);
    check("R11 irq masked", irq, 0);
    wr_reg(3'd0, 32'h5);
    check("R11 irq back", irq, 1);
    wr_reg(3'd4, 32'd1);
    rd_reg(3'd4, rd); check("R10 w1c", rd, 0);
    check("R11 irq low", irq, 0);
    ticks(10); @(negedge clk);
    check("R4 second timeout resets", n_rst - r0, 1);
    ticks(10); @(negedge clk);
    wr_reg(3'd4, 32'd1);
    service();
    ticks(10); @(negedge clk);
    check("R5 service cancels escalation", n_rst - r0, 1);
    rd_reg(3'd4, rd); check("R4 flag again", rd, 1);
    wr_reg(3'd4, 32'd1);
    wr_reg(3'd0, 32'd0);

    // R8 R9 invalid access with reset response
    wr_reg(3'd1, 32'd100);
    wr_reg(3'd0, 32'h9);
    r0 = n_rst; e0 = n_err;
    wr_reg(3'd3, 32'h0000_B480);
    @(negedge clk);
    check("R8 out of order resets", n_rst - r0, 1);
    wr_reg(3'd3, 32'h0000_A602);
    wr_reg(3'd3, 32'h0000_1234);
    @(negedge clk);
    check("R9 wrong key resets", n_rst - r0, 2);
    check("R9 no bus error", n_err - e0, 0);
    wr_reg(3'd0, 32'd0);
    rd_reg(3'd5, rd); check("R8 no reload", rd, 100);

    // R12 disabled key writes ignored
    r0 = n_rst; e0 = n_err;
    wr_reg(3'd3, 32'h0000_0000);
    wr_reg(3'd3, 32'h0000_B480);
    @(negedge clk);
    check("R12 no response", (n_rst - r0) + (n_err - e0), 0);
    rd_reg(3'd5, rd); check("R12 count kept", rd, 100);

    finish_run();
  end
endmodule